// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block evaluates a compare predicate on two single-precision IEEE-754 operands and records the one-bit outcome in one of eight condition codes. A 4-bit condition field picks which relations count as true: less-than, equal and unordered. A fourth bit makes the compare signaling, so that a NaN operand raises an invalid-operation event instead of updating a code. The eight codes also appear inside a 32-bit control/status word at fixed, non-contiguous positions. Software may rewrite either view through a small write port, and the other view follows. A branch-test output reports whether a chosen code matches a requested true/false sense.

A compare is taken by a two-state sequencer. In state IDLE a strobe captures the operands, condition field and target index, and the sequencer moves to EVAL (transition ACCEPT). In EVAL the captured compare is committed. A further strobe in that cycle keeps the sequencer in EVAL (transition CHAIN). Without one it returns to IDLE (transition RETIRE). With no strobe, IDLE holds (transition WAIT). Only one copy of the codes is stored. The status word is assembled from that copy and from the remaining non-code bits.

Top module: `fpcc_unit`

## Requirements
- R1: The condition field encodes bit 0 as unordered-enable, bit 1 as equal-enable, bit 2 as less-enable and bit 3 as signaling. The result is (bit2 AND less) OR (bit1 AND equal) OR (bit0 AND unordered).
- R2: Ordering treats each operand as sign and magnitude: a set sign bit (bit 31) means negative. Positive zero and negative zero compare equal.
- R3: If either operand is a NaN (exponent bits 30:23 all ones with a nonzero fraction), less and equal are 0 and unordered is 1.
- R4: A NaN operand with the signaling bit set drives `inv_o` high for exactly one cycle and leaves every condition code unchanged. A NaN operand with the signaling bit clear gives no pulse.
- R5: A compare strobed at clock edge k writes only code `cmp_idx` at edge k+1. `inv_o` is also valid from edge k+1. All other codes keep their values.
- R6: In `stat_o`, code 0 appears at bit 23 and code n (1 to 7) appears at bit 24+n.
- R7: A control write with `ctl_sel`=0 loads the codes from `ctl_wdata[7:0]` at that edge. The code bits of `stat_o` follow, and its other bits are unchanged.
- R8: A control write with `ctl_sel`=1 stores `ctl_wdata` ANDed with `STAT_MASK` (default 0xFE83FFFF). It rebuilds code n from the data bit given in R6.
- R9: A status write whose data has any bit outside `STAT_MASK` set pulses `mode_err_o` for one cycle after that edge. The masked value is still stored.
- R10: `br_true` is 1 exactly when code `br_idx` equals `br_sense`, combinationally.
- R11: After reset the codes, `stat_o`, `inv_o` and `mode_err_o` are all 0.
- R12: When a compare commits in the same edge as a control write, the written value applies to all codes except the compared one, which takes the compare result.
- R13: Strobes on consecutive cycles are each committed one edge after their own strobe, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_stb | input | 1 | Compare request |
| cmp_a | input | 32 | First operand bit pattern |
| cmp_b | input | 32 | Second operand bit pattern |
| cmp_cond | input | 4 | Condition field |
| cmp_idx | input | 3 | Target condition code |
| ctl_we | input | 1 | Control write enable |
| ctl_sel | input | 1 | 0: code register, 1: status word |
| ctl_wdata | input | 32 | Control write data |
| br_idx | input | 3 | Code examined by the branch test |
| br_sense | input | 1 | Required code value for the branch test |
| cc_o | output | 8 | Condition codes |
| stat_o | output | 32 | Control/status word |
| inv_o | output | 1 | Invalid-operation pulse |
| mode_err_o | output | 1 | Unsupported-mode write pulse |
| br_true | output | 1 | Branch-test result |

## Verification
The bench builds the block with its default parameters: 32-bit operands with an 8-bit exponent, eight codes and the default status mask. These values reach every mirror position, including code 7 at the top bit and code 0 below the unsupported bit 24. They also let both writable and unsupported status bits be driven. Random operands are drawn from zeros of both signs, infinities, NaNs and finite values, so sign-magnitude ordering and every unordered path are exercised. Directed cases cover back-to-back strobes and a compare that commits in the same edge as a control write.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_EVAL = 1'b1
    } seq_state_e;

    localparam int COND_UN  = 0;
    localparam int COND_EQ  = 1;
    localparam int COND_LT  = 2;
    localparam int COND_SIG = 3;

    typedef struct packed {
        logic lt;
        logic eq;
        logic un;
    } rel_t;

    // status-word bit that mirrors condition code n
    function automatic int cc_stat_pos(input int n);
        return (n == 0) ? 23 : 24 + n;
    endfunction

endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
    import fpcc_pkg::*;
#(
    parameter int FLT_W = 32,
    parameter int EXP_W = 8
) (
    input  logic [FLT_W-1:0] op_a,
    input  logic [FLT_W-1:0] op_b,
    output rel_t             rel
);
    localparam int MAN_W = FLT_W - 1 - EXP_W;
    localparam int MAG_W = FLT_W - 1;

    logic             nan_a, nan_b, unord;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             sgn_a, sgn_b, both_zero, ord_lt;

    always_comb begin
        mag_a = op_a[MAG_W-1:0];
        mag_b = op_b[MAG_W-1:0];
        sgn_a = op_a[FLT_W-1];
        sgn_b = op_b[FLT_W-1];
        nan_a = (&op_a[FLT_W-2 -: EXP_W]) && (|op_a[MAN_W-1:0]);
        nan_b = (&op_b[FLT_W-2 -: EXP_W]) && (|op_b[MAN_W-1:0]);
        unord = nan_a | nan_b;
        both_zero = (mag_a == '0) && (mag_b == '0);
        unique case ({sgn_a, sgn_b})
            2'b10:   ord_lt = !both_zero;
            2'b01:   ord_lt = 1'b0;
            2'b00:   ord_lt = mag_a < mag_b;
            default: ord_lt = mag_a > mag_b;
        endcase
        rel.un = unord;
        rel.eq = !unord && (both_zero || (op_a == op_b));
        rel.lt = !unord && ord_lt;
    end

endmodule

// File: rtl/fpcc_seq.sv
module fpcc_seq
    import fpcc_pkg::*;
#(
    parameter int FLT_W = 32,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [FLT_W-1:0] a,
    input  logic [FLT_W-1:0] b,
    input  logic [3:0]       cond,
    input  logic [IDX_W-1:0] idx,
    output logic             commit,
    output logic [FLT_W-1:0] h_a,
    output logic [FLT_W-1:0] h_b,
    output logic [3:0]       h_cond,
    output logic [IDX_W-1:0] h_idx
);
    seq_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= SEQ_IDLE;
        else     st_q <= st_d;
    end

    // transitions: WAIT, ACCEPT, CHAIN, RETIRE
    always_comb begin
        unique case (st_q)
            SEQ_IDLE: st_d = stb ? SEQ_EVAL : SEQ_IDLE;
            SEQ_EVAL: st_d = stb ? SEQ_EVAL : SEQ_IDLE;
            default:  st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_a    <= '0;
            h_b    <= '0;
            h_cond <= '0;
            h_idx  <= '0;
        end else if (stb) begin
            h_a    <= a;
            h_b    <= b;
            h_cond <= cond;
            h_idx  <= idx;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            SEQ_EVAL: commit = 1'b1;
            default:  commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpcc_regs.sv
module fpcc_regs
    import fpcc_pkg::*;
#(
    parameter int              CC_N      = 8,
    parameter int              STAT_W    = 32,
    parameter logic [STAT_W-1:0] STAT_MASK = 32'hFE83_FFFF,
    parameter int              IDX_W     = $clog2(CC_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              cmp_res,
    input  logic              cmp_inv,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic              ctl_we,
    input  logic              ctl_sel,
    input  logic [STAT_W-1:0] ctl_wdata,
    output logic [CC_N-1:0]   cc,
    output logic [STAT_W-1:0] stat,
    output logic              inv_o,
    output logic              mode_err_o
);
    function automatic logic [STAT_W-1:0] cc_field_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int n = 0; n < CC_N; n++) m[cc_stat_pos(n)] = 1'b1;
        return m;
    endfunction

    localparam logic [STAT_W-1:0] CC_BITS   = cc_field_mask();
    localparam logic [STAT_W-1:0] REST_MASK = STAT_MASK & ~CC_BITS;

    logic [CC_N-1:0]   cc_q, cc_d, cc_from_stat, cc_wr;
    logic [STAT_W-1:0] rest_q, rest_d, mirror;

    for (genvar n = 0; n < CC_N; n++) begin : g_map
        assign cc_from_stat[n]         = ctl_wdata[cc_stat_pos(n)];
    end

    always_comb begin
        mirror = '0;
        for (int n = 0; n < CC_N; n++) mirror[cc_stat_pos(n)] = cc_q[n];
    end

    always_comb begin
        cc_wr = cc_q;
        if (ctl_we) cc_wr = ctl_sel ? cc_from_stat : ctl_wdata[CC_N-1:0];
        cc_d = cc_wr;
        if (commit && !cmp_inv) cc_d[cmp_idx] = cmp_res;
        rest_d = (ctl_we && ctl_sel) ? (ctl_wdata & REST_MASK) : rest_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q       <= '0;
            rest_q     <= '0;
            inv_o      <= 1'b0;
            mode_err_o <= 1'b0;
        end else begin
            cc_q       <= cc_d;
            rest_q     <= rest_d;
            inv_o      <= commit && cmp_inv;
            mode_err_o <= ctl_we && ctl_sel && (|(ctl_wdata & ~STAT_MASK));
        end
    end

    assign cc   = cc_q;
    assign stat = rest_q | mirror;

endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int                FLT_W     = 32,
    parameter int                EXP_W     = 8,
    parameter int                CC_N      = 8,
    parameter int                STAT_W    = 32,
    parameter logic [STAT_W-1:0] STAT_MASK = 32'hFE83_FFFF,
    parameter int                IDX_W     = $clog2(CC_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_stb,
    input  logic [FLT_W-1:0]  cmp_a,
    input  logic [FLT_W-1:0]  cmp_b,
    input  logic [3:0]        cmp_cond,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic              ctl_we,
    input  logic              ctl_sel,
    input  logic [STAT_W-1:0] ctl_wdata,
    input  logic [IDX_W-1:0]  br_idx,
    input  logic              br_sense,
    output logic [CC_N-1:0]   cc_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              inv_o,
    output logic              mode_err_o,
    output logic              br_true
);
    logic             commit;
    logic [FLT_W-1:0] h_a, h_b;
    logic [3:0]       h_cond;
    logic [IDX_W-1:0] h_idx;
    rel_t             rel;
    logic             res, inv;

    fpcc_seq #(.FLT_W(FLT_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .stb(cmp_stb), .a(cmp_a), .b(cmp_b),
        .cond(cmp_cond), .idx(cmp_idx), .commit(commit),
        .h_a(h_a), .h_b(h_b), .h_cond(h_cond), .h_idx(h_idx)
    );

    fpcc_classify #(.FLT_W(FLT_W), .EXP_W(EXP_W)) u_cls (
        .op_a(h_a), .op_b(h_b), .rel(rel)
    );

    always_comb begin
        res = (h_cond[COND_LT] & rel.lt) | (h_cond[COND_EQ] & rel.eq)
            | (h_cond[COND_UN] & rel.un);
        inv = h_cond[COND_SIG] & rel.un;
    end

    fpcc_regs #(.CC_N(CC_N), .STAT_W(STAT_W), .STAT_MASK(STAT_MASK), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .commit(commit), .cmp_res(res), .cmp_inv(inv),
        .cmp_idx(h_idx), .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .cc(cc_o), .stat(stat_o), .inv_o(inv_o), .mode_err_o(mode_err_o)
    );

    assign br_true = (cc_o[br_idx] == br_sense);

endmodule

// File: rtl/fpcc_chk.sv
module fpcc_chk #(
    parameter int                CC_N   = 8,
    parameter int                STAT_W = 32,
    parameter logic [STAT_W-1:0] MASK   = 32'hFE83_FFFF
) (
    input logic              clk,
    input logic              rst,
    input logic              cmp_stb,
    input logic [3:0]        cmp_cond,
    input logic              ctl_we,
    input logic              ctl_sel,
    input logic [STAT_W-1:0] ctl_wdata,
    input logic [CC_N-1:0]   cc_o,
    input logic [STAT_W-1:0] stat_o,
    input logic              inv_o,
    input logic              mode_err_o
);
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cc_o == '0 && stat_o == '0 && !inv_o && !mode_err_o));

    // R5
    cc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmp_stb, 2) && !$past(ctl_we)) |-> $stable(cc_o));

    // R4
    inv_source_chk: assert property (@(posedge clk) disable iff (rst)
        inv_o |-> ($past(cmp_stb, 2) && $past(cmp_cond[3], 2)));

    // R4
    inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_o && !$past(ctl_we)) |-> (cc_o == $past(cc_o)));

    // R9
    mode_err_src_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err_o |-> $past(ctl_we && ctl_sel));

    // R7
    cc_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_we && !ctl_sel) && !$past(cmp_stb, 2))
            |-> (cc_o == $past(ctl_wdata[CC_N-1:0])));

    // R8
    stat_rebuild_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_we && ctl_sel) && !$past(cmp_stb, 2))
            |-> (cc_o == {$past(ctl_wdata[31:25]), $past(ctl_wdata[23])}));

    // R8
    stat_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_o & ~MASK) == '0);

endmodule

bind fpcc_unit fpcc_chk #(.CC_N(CC_N), .STAT_W(STAT_W), .MASK(STAT_MASK)) u_chk (
    .clk(clk), .rst(rst), .cmp_stb(cmp_stb), .cmp_cond(cmp_cond),
    .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .cc_o(cc_o), .stat_o(stat_o), .inv_o(inv_o), .mode_err_o(mode_err_o)
);

// File: tb/sim_fpcc_unit.sv
module sim_fpcc_unit;
    localparam logic [31:0] MASK   = 32'hFE83_FFFF;
    localparam logic [31:0] CCBITS = 32'hFE80_0000;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cmp_stb = 1'b0, ctl_we = 1'b0, ctl_sel = 1'b0, br_sense = 1'b0;
    logic [31:0] cmp_a = '0, cmp_b = '0, ctl_wdata = '0;
    logic [3:0]  cmp_cond = '0;
    logic [2:0]  cmp_idx = '0, br_idx = '0;
    logic [7:0]  cc_o;
    logic [31:0] stat_o;
    logic        inv_o, mode_err_o, br_true;

    int total = 0, bad = 0;
    logic [7:0]  m_cc = '0;
    logic [31:0] m_rest = '0;

    always #4 clk = ~clk;

    fpcc_unit u0 (
        .clk(clk), .rst(rst), .cmp_stb(cmp_stb), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cmp_cond(cmp_cond), .cmp_idx(cmp_idx), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
        .ctl_wdata(ctl_wdata), .br_idx(br_idx), .br_sense(br_sense),
        .cc_o(cc_o), .stat_o(stat_o), .inv_o(inv_o), .mode_err_o(mode_err_o),
        .br_true(br_true)
    );

    function automatic logic f_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic longint f_key(input logic [31:0] x);
        longint m;
        m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    // returns {inv, res}
    function automatic logic [1:0] f_pred(input logic [31:0] a, b, input logic [3:0] c);
        logic un, lt, eq;
        un = f_nan(a) || f_nan(b);
        lt = !un && (f_key(a) < f_key(b));
        eq = !un && (f_key(a) == f_key(b));
        return {c[3] & un, (c[2] & lt) | (c[1] & eq) | (c[0] & un)};
    endfunction

    function automatic logic [31:0] f_stat(input logic [7:0] c, input logic [31:0] rest);
        logic [31:0] s;
        s = rest;
        s[23] = c[0];
        for (int n = 1; n < 8; n++) s[24+n] = c[n];
        return s;
    endfunction

    function automatic logic [31:0] f_pick();
        logic [31:0] v;
        v = $urandom;
        unique case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return {v[31], 8'hFF, 1'b1, v[21:0]};
            3: return {v[31], 8'hFF, 23'h0};
            4: return {v[31], 4'h8, v[3:0], 23'h0};
            default: return {v[31], 5'b10000, v[25:0]};
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_cmp(input logic [31:0] a, b, input logic [3:0] c,
                          input logic [2:0] idx, input string req);
        logic [1:0] p;
        p = f_pred(a, b, c);
        if (!p[1]) m_cc[idx] = p[0];
        @(negedge clk);
        cmp_stb = 1'b1; cmp_a = a; cmp_b = b; cmp_cond = c; cmp_idx = idx;
        @(negedge clk);
        cmp_stb = 1'b0;
        @(negedge clk);
        chk(req, "cc", {24'h0, cc_o}, {24'h0, m_cc});
        chk(req, "inv", {31'h0, inv_o}, {31'h0, p[1]});
        chk(req, "stat", stat_o, f_stat(m_cc, m_rest));
    endtask

    task automatic do_ctl(input logic sel, input logic [31:0] d, input string req);
        logic err;
        err = 1'b0;
        if (sel) begin
            m_rest = d & MASK & ~CCBITS;
            m_cc = {d[31:25], d[23]};
            err = |(d & ~MASK);
        end else begin
            m_cc = d[7:0];
        end
        @(negedge clk);
        ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
        chk(req, "cc", {24'h0, cc_o}, {24'h0, m_cc});
        chk(req, "stat", stat_o, f_stat(m_cc, m_rest));
        chk(req, "mode_err", {31'h0, mode_err_o}, {31'h0, err});
        @(negedge clk);
        chk(req, "mode_err end", {31'h0, mode_err_o}, 32'h0);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [1:0]  p1, p2;
        logic [31:0] wv;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk("R11", "cc", {24'h0, cc_o}, 32'h0);
        chk("R11", "stat", stat_o, 32'h0);
        chk("R11", "pulses", {30'h0, inv_o, mode_err_o}, 32'h0);

        // R2 zeros and sign-magnitude order
        do_cmp(32'h0000_0000, 32'h8000_0000, 4'b0010, 3'd1, "R2");
        chk("R2", "+0==-0", {31'h0, cc_o[1]}, 32'h1);
        do_cmp(32'hBF80_0000, 32'h3F80_0000, 4'b0100, 3'd2, "R2");
        chk("R2", "-1<1", {31'h0, cc_o[2]}, 32'h1);
        do_cmp(32'hC000_0000, 32'hBF80_0000, 4'b0100, 3'd3, "R2");
        chk("R2", "-2<-1", {31'h0, cc_o[3]}, 32'h1);
        // R3 quiet NaN
        do_cmp(32'h7FC0_0001, 32'h3F80_0000, 4'b0111, 3'd4, "R3");
        chk("R3", "unord", {31'h0, cc_o[4]}, 32'h1);
        do_cmp(32'h3F80_0000, 32'hFFC0_0000, 4'b0110, 3'd4, "R3");
        chk("R3", "lt/eq off", {31'h0, cc_o[4]}, 32'h0);
        // R4 signaling NaN keeps codes
        do_ctl(1'b0, 32'h0000_00A5, "R7");
        do_cmp(32'h7F80_0010, 32'h0000_0000, 4'b1111, 3'd6, "R4");
        chk("R4", "cc kept", {24'h0, cc_o}, 32'hA5);
        @(negedge clk);
        chk("R4", "inv one cycle", {31'h0, inv_o}, 32'h0);

        // R1 R5 random compares
        for (int i = 0; i < 300; i++)
            do_cmp(f_pick(), f_pick(), 4'($urandom), 3'($urandom), "R1");

        // R6 R7 code writes
        for (int i = 0; i < 10; i++) do_ctl(1'b0, $urandom, "R6");
        // R8 R9 status writes
        do_ctl(1'b1, 32'hFE83_FFFF, "R8");
        do_ctl(1'b1, 32'h017C_0000, "R9");
        do_ctl(1'b1, 32'hFFFF_FFFF, "R9");
        for (int i = 0; i < 10; i++) do_ctl(1'b1, $urandom, "R8");

        // R10 branch test
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            br_idx = 3'(i); br_sense = i[3];
            #1;
            chk("R10", "br", {31'h0, br_true}, {31'h0, m_cc[i[2:0]] == i[3]});
        end

        // R13 back-to-back strobes
        do_ctl(1'b0, 32'h0, "R13");
        p1 = f_pred(32'h3F80_0000, 32'h4000_0000, 4'b0100);
        p2 = f_pred(32'h4000_0000, 32'h4000_0000, 4'b0010);
        @(negedge clk);
        cmp_stb = 1'b1; cmp_a = 32'h3F80_0000; cmp_b = 32'h4000_0000; cmp_cond = 4'b0100; cmp_idx = 3'd0;
        @(negedge clk);
        cmp_a = 32'h4000_0000; cmp_cond = 4'b0010; cmp_idx = 3'd7;
        @(negedge clk);
        cmp_stb = 1'b0;
        chk("R13", "first", {24'h0, cc_o}, {31'h0, p1[0]});
        @(negedge clk);
        chk("R13", "second", {24'h0, cc_o}, {p2[0], 6'h0, p1[0]});
        m_cc = {p2[0], 6'h0, p1[0]};

        // R12 compare and code write in one edge
        p1 = f_pred(32'h0000_0000, 32'h3F80_0000, 4'b0100);
        @(negedge clk);
        cmp_stb = 1'b1; cmp_a = 32'h0000_0000; cmp_b = 32'h3F80_0000; cmp_cond = 4'b0100; cmp_idx = 3'd5;
        @(negedge clk);
        cmp_stb = 1'b0; ctl_we = 1'b1; ctl_sel = 1'b0; ctl_wdata = 32'h0000_000F;
        @(negedge clk);
        ctl_we = 1'b0;
        wv = 32'h0000_000F;
        wv[5] = p1[0];
        chk("R12", "merge", {24'h0, cc_o}, wv);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule